// File: doc/BRIEF.md
# Deferred Flash Write Gate

This block sits between the byte-store path of a small processor and the programming port of an on-chip flash, and it decides the cycle in which each store reaches the flash. When deferral is switched on and a measurement engine is enabled, a store is parked in a single holding slot. It is released in the cycle after the engine's busy line falls, so the flash write current never overlaps a measurement. When deferral is off, or the engine is disabled, stores go straight through. A held store is also flushed as soon as deferral stops applying.

Software controls the gate through two small registers. The control register holds a program-enable bit and a deferral enable. The key register holds a 4-bit unlock field. The program-enable bit turns the next byte store into a flash store and clears itself once that byte is taken. Software cannot set it while interrupts are globally enabled. No flash store is accepted unless the unlock field holds 2. A secure input sets two permission flags for debug and serial access.

Top module: `flash_write_gate`

## Requirements
- R1: With deferral enabled (control bit 1 = 1) and `eng_en` = 1, an accepted store into an empty slot produces no strobe and raises `pend` on the next clock.
- R2: A held store is issued, with its own address and data, in the cycle after the clock edge at which `eng_busy` is first sampled 0 after being sampled 1, and `pend` clears then unless R10 applies.
- R3: If deferral is disabled or `eng_en` = 0 and the slot is empty, an accepted store drives `fl_wr` = 1 with its address and data on the next clock, for one cycle.
- R4: A store is accepted only while the program-enable bit (control bit 0) is 1. Acceptance clears that bit on the next clock. A store made while the bit is 0 gives no strobe.
- R5: While `irq_en` = 1, a control-register write (`reg_sel` = 0) leaves the program-enable bit unchanged. The deferral bit is still written.
- R6: While the unlock field (`reg_sel` = 1, bits 3:0) differs from 2, a store is ignored: no strobe, no capture, and the program-enable bit keeps its value.
- R7: `rd_perm` equals the inverse of `secure`. `wr_perm` is 1 only when `secure` = 0 and the unlock field is 2.
- R8: An accepted store that arrives while the slot is full and not being released is dropped. It sets the sticky `ovf`, and the held store stays intact.
- R9: When deferral stops applying (`eng_en` or the deferral bit goes to 0) while a store is held, that store is issued on the next clock.
- R10: When a release and a new accepted store fall in the same cycle, the held store is issued, the new store is captured, `pend` stays 1, and `ovf` is not set.
- R11: After reset, `fl_wr`, `pend`, `ovf`, `pwe_o` and the deferral bit are 0, and the unlock field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Byte store request from the processor |
| req_addr | input | AW | Store address |
| req_data | input | DW | Store data |
| eng_en | input | 1 | Measurement engine enabled |
| eng_busy | input | 1 | Measurement engine busy |
| secure | input | 1 | Secure mode |
| irq_en | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects key register |
| reg_wdata | input | KEY_W | Register write data |
| fl_wr | output | 1 | Flash write strobe, one cycle per byte |
| fl_addr | output | AW | Flash write address |
| fl_data | output | DW | Flash write data |
| pend | output | 1 | Holding slot occupied |
| ovf | output | 1 | Sticky: a store was dropped |
| pwe_o | output | 1 | Current program-enable bit |
| rd_perm | output | 1 | Debug/serial read permitted |
| wr_perm | output | 1 | Debug/serial write permitted |

## Verification
The release of a held store and the arrival of a new store can land in the same clock. The bench sets this up by parking one byte while busy is high, re-arming program-enable, and then lowering busy in the very cycle a second store is presented. It passes only if the first byte is strobed out, `pend` stays high, `ovf` stays low, and the second byte comes out at the next busy fall with its own address and data.

// File: rtl/fwg_pkg.sv
// Package: shared constants and register selector type for the flash write gate.
// Assumes: unlock field is 4 bits wide; control bits sit in the low bits.
package fwg_pkg;
    localparam int          KEY_BITS       = 4;
    localparam logic [3:0]  UNLOCK_VALUE   = 4'd2;
    localparam int          CTRL_PWE_BIT   = 0;
    localparam int          CTRL_DEFER_BIT = 1;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_KEY  = 1'b1
    } fwg_sel_e;
endpackage

// File: rtl/fwg_cfg_regs.sv
// Module: software-visible configuration of the gate.
// Holds program-enable, deferral enable and unlock field. Program-enable
// cannot be set while interrupts are enabled, and it clears whenever a
// flash byte is accepted (byte_done). A clear from byte_done overrides a
// same-cycle software write.
module fwg_cfg_regs
    import fwg_pkg::*;
#(
    parameter int KEY_W = KEY_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [KEY_W-1:0] reg_wdata,
    input  logic             irq_en,
    input  logic             byte_done,
    output logic             pwe,
    output logic             defer_en,
    output logic             key_ok
);
    logic [KEY_W-1:0] key_q;
    logic             wr_ctrl;
    logic             wr_key;

    // Decode which register a software write targets.
    always_comb begin
        wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
        wr_key  = reg_wr && (reg_sel == SEL_KEY);
        key_ok  = (key_q == KEY_W'(UNLOCK_VALUE));
    end

    // Update control bits; auto-clear of program-enable has the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwe      <= 1'b0;
            defer_en <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                defer_en <= reg_wdata[CTRL_DEFER_BIT];
                if (!irq_en) pwe <= reg_wdata[CTRL_PWE_BIT];
            end
            if (byte_done) pwe <= 1'b0;
        end
    end

    // Update the unlock field.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (wr_key) key_q <= reg_wdata;
    end

    // R4
    pwe_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !pwe);

    // R5
    pwe_irq_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |=> !$rose(pwe));
endmodule

// File: rtl/fwg_busy_edge.sv
// Module: detects the falling edge of the engine busy signal.
// Assumes eng_busy is synchronous to clk. fall is high in the cycle where
// busy is 0 and the previous sample was 1.
module fwg_busy_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic fall
);
    logic busy_q;

    // Keep the previous busy sample.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Falling edge: was busy, now idle.
    always_comb fall = busy_q && !busy;
endmodule

// File: rtl/fwg_hold_slot.sv
// Module: one-entry holding slot and registered flash strobe.
// acc is an accepted flash store. defer says whether stores must wait.
// A held entry is released on busy_fall or as soon as defer is 0. A store
// that meets a release in the same cycle refills the slot. A store that
// meets a full, unreleased slot is dropped and sets the sticky ovf.
module fwg_hold_slot #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          defer,
    input  logic          busy_fall,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          issue,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic          pend,
    output logic          ovf
);
    logic [AW-1:0] slot_addr;
    logic [DW-1:0] slot_data;
    logic          release_now;
    logic          pass_now;
    logic          capture_now;
    logic          drop_now;

    // Decide this cycle's action for the slot and the strobe.
    always_comb begin
        release_now = pend && (!defer || busy_fall);
        pass_now    = acc && !defer && !pend;
        capture_now = acc && (defer || pend) && (!pend || release_now);
        drop_now    = acc && pend && !release_now;
    end

    // Drive the flash strobe and its address/data, one pulse per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue    <= 1'b0;
            out_addr <= '0;
            out_data <= '0;
        end else begin
            issue <= release_now || pass_now;
            if (release_now) begin
                out_addr <= slot_addr;
                out_data <= slot_data;
            end else if (pass_now) begin
                out_addr <= req_addr;
                out_data <= req_data;
            end
        end
    end

    // Maintain slot occupancy and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (capture_now)      pend <= 1'b1;
            else if (release_now) pend <= 1'b0;
            if (drop_now)         ovf  <= 1'b1;
        end
    end

    // Load the slot contents on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_addr <= '0;
            slot_data <= '0;
        end else if (capture_now) begin
            slot_addr <= req_addr;
            slot_data <= req_data;
        end
    end

    // R1
    defer_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && defer && !pend) |=> (pend && !issue));

    // R2
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && defer && busy_fall) |=> (issue && out_addr == $past(slot_addr)
                                          && out_data == $past(slot_data)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R8
    drop_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pend && defer && !busy_fall) |=> (pend && ovf
                                                  && slot_addr == $past(slot_addr)));

    // R9
    flush_on_undefer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !defer) |=> issue);

    // R10
    release_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pend && defer && busy_fall) |=> (issue && pend && ovf == $past(ovf)));
endmodule

// File: rtl/flash_write_gate.sv
// Module: top of the deferred flash write gate.
// Accepts processor byte stores, qualifies them with program-enable and the
// unlock key, and either passes them to the flash port or parks one while
// the measurement engine is busy. Also drives debug/serial permission flags.
// Assumes all inputs are synchronous to clk.
module flash_write_gate
    import fwg_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int KEY_W = KEY_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic             eng_en,
    input  logic             eng_busy,
    input  logic             secure,
    input  logic             irq_en,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [KEY_W-1:0] reg_wdata,
    output logic             fl_wr,
    output logic [AW-1:0]    fl_addr,
    output logic [DW-1:0]    fl_data,
    output logic             pend,
    output logic             ovf,
    output logic             pwe_o,
    output logic             rd_perm,
    output logic             wr_perm
);
    logic pwe;
    logic defer_en;
    logic key_ok;
    logic busy_fall;
    logic accept;
    logic defer;

    // Qualify stores and select the deferral condition.
    always_comb begin
        accept  = req_valid && pwe && key_ok;
        defer   = defer_en && eng_en;
        pwe_o   = pwe;
        rd_perm = !secure;
        wr_perm = !secure && key_ok;
    end

    fwg_cfg_regs #(.KEY_W(KEY_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .irq_en    (irq_en),
        .byte_done (accept),
        .pwe       (pwe),
        .defer_en  (defer_en),
        .key_ok    (key_ok)
    );

    fwg_busy_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (eng_busy),
        .fall  (busy_fall)
    );

    fwg_hold_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (accept),
        .defer     (defer),
        .busy_fall (busy_fall),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .issue     (fl_wr),
        .out_addr  (fl_addr),
        .out_data  (fl_data),
        .pend      (pend),
        .ovf       (ovf)
    );

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !defer && !pend) |=> (fl_wr && fl_addr == $past(req_addr)
                                         && fl_data == $past(req_data)));

    // R6
    locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !key_ok && !pend) |=> (!fl_wr && !pend));
endmodule

// File: tb/flash_write_gate_test.sv
module flash_write_gate_test;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          eng_en, eng_busy, secure, irq_en;
    logic          reg_wr, reg_sel;
    logic [3:0]    reg_wdata;
    logic          fl_wr, pend, ovf, pwe_o, rd_perm, wr_perm;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    flash_write_gate #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .eng_en(eng_en), .eng_busy(eng_busy),
        .secure(secure), .irq_en(irq_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .fl_wr(fl_wr), .fl_addr(fl_addr),
        .fl_data(fl_data), .pend(pend), .ovf(ovf), .pwe_o(pwe_o),
        .rd_perm(rd_perm), .wr_perm(wr_perm)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [3:0] val);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_addr = a; req_data = d;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 0; req_addr = '0; req_data = '0;
        eng_en = 0; eng_busy = 0; secure = 0; irq_en = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R11 fl_wr", fl_wr, 0);
        check("R11 pend", pend, 0);
        check("R11 ovf", ovf, 0);
        check("R11 pwe", pwe_o, 0);
        check("R11 unlock zero -> wr_perm", wr_perm, 0);
    endtask

    task automatic t_perm();
        secure = 1'b1; #1;
        check("R7 rd_perm secure", rd_perm, 0);
        write_reg(1'b1, 4'd2);
        check("R7 wr_perm secure", wr_perm, 0);
        secure = 1'b0; #1;
        check("R7 rd_perm open", rd_perm, 1);
        check("R7 wr_perm open", wr_perm, 1);
        write_reg(1'b1, 4'd3);
        check("R7 wr_perm bad key", wr_perm, 0);
    endtask

    task automatic t_lock();
        write_reg(1'b1, 4'd5);
        write_reg(1'b0, 4'b0001);
        store(16'h1111, 8'h11);
        check("R6 no strobe locked", fl_wr, 0);
        check("R6 no capture locked", pend, 0);
        check("R6 pwe kept", pwe_o, 1);
        write_reg(1'b1, 4'd2);
    endtask

    task automatic t_immediate();
        eng_en = 1'b1;
        write_reg(1'b0, 4'b0001);
        store(16'hA001, 8'h5A);
        check("R3 strobe", fl_wr, 1);
        check("R3 addr", fl_addr, 16'hA001);
        check("R3 data", fl_data, 8'h5A);
        check("R4 pwe cleared", pwe_o, 0);
        tick();
        check("R3 single pulse", fl_wr, 0);
        store(16'hA002, 8'h77);
        check("R4 no strobe without pwe", fl_wr, 0);
        eng_en = 1'b0;
        write_reg(1'b0, 4'b0011);
        store(16'hA003, 8'h3C);
        check("R3 engine off strobe", fl_wr, 1);
        check("R3 engine off addr", fl_addr, 16'hA003);
        check("R3 engine off no pend", pend, 0);
    endtask

    task automatic t_irq();
        irq_en = 1'b1;
        write_reg(1'b0, 4'b0001);
        check("R5 pwe blocked", pwe_o, 0);
        irq_en = 1'b0;
        write_reg(1'b0, 4'b0001);
        check("R5 pwe set when irq off", pwe_o, 1);
        write_reg(1'b0, 4'b0000);
    endtask

    task automatic t_defer();
        eng_en = 1'b1; eng_busy = 1'b1;
        write_reg(1'b0, 4'b0011);
        store(16'hB010, 8'hC1);
        check("R1 no strobe", fl_wr, 0);
        check("R1 pend", pend, 1);
        tick(); tick();
        check("R2 held while busy", fl_wr, 0);
        eng_busy = 1'b0;
        tick();
        check("R2 strobe on fall", fl_wr, 1);
        check("R2 addr", fl_addr, 16'hB010);
        check("R2 data", fl_data, 8'hC1);
        check("R2 pend cleared", pend, 0);
    endtask

    task automatic t_same_cycle();
        eng_busy = 1'b1;
        write_reg(1'b0, 4'b0011);
        store(16'hC020, 8'hD2);
        write_reg(1'b0, 4'b0011);
        eng_busy = 1'b0;
        store(16'hC021, 8'hD3);
        check("R10 held issued", fl_wr, 1);
        check("R10 held addr", fl_addr, 16'hC020);
        check("R10 pend stays", pend, 1);
        check("R10 no ovf", ovf, 0);
        eng_busy = 1'b1;
        tick();
        check("R10 new held", fl_wr, 0);
        eng_busy = 1'b0;
        tick();
        check("R10 new issued", fl_wr, 1);
        check("R10 new addr", fl_addr, 16'hC021);
        check("R10 new data", fl_data, 8'hD3);
    endtask

    task automatic t_engdrop();
        eng_busy = 1'b1;
        write_reg(1'b0, 4'b0011);
        store(16'hD030, 8'hE4);
        check("R9 pend", pend, 1);
        eng_en = 1'b0;
        tick();
        check("R9 flush strobe", fl_wr, 1);
        check("R9 flush addr", fl_addr, 16'hD030);
        check("R9 pend cleared", pend, 0);
        eng_en = 1'b1;
    endtask

    task automatic t_ovf();
        eng_busy = 1'b1;
        write_reg(1'b0, 4'b0011);
        store(16'hE040, 8'hF5);
        write_reg(1'b0, 4'b0011);
        store(16'hE041, 8'hF6);
        check("R8 ovf set", ovf, 1);
        check("R8 pend kept", pend, 1);
        check("R8 no strobe", fl_wr, 0);
        eng_busy = 1'b0;
        tick();
        check("R8 first kept addr", fl_addr, 16'hE040);
        check("R8 first kept data", fl_data, 8'hF5);
        tick();
        check("R8 dropped not issued", fl_wr, 0);
        check("R8 ovf sticky", ovf, 1);
    endtask

    initial begin
        t_reset();
        t_perm();
        t_lock();
        t_immediate();
        t_irq();
        t_defer();
        t_same_cycle();
        t_engdrop();
        t_ovf();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule